// File: doc/BRIEF.md
# Beat-Stream CRC-32 Accumulator

This block sits on the read-data path of a DMA channel and folds every accepted data beat into a running CRC-32 checksum. A beat may be 8, 16 or 32 bits wide, and the width may change from one beat to the next. The checksum register is loaded by software with a starting value, and then the block updates it as the channel reads data. It keeps accumulating across linked blocks until software writes a new seed.

No separate enable bit exists. The engine runs only while a source-select code picks DMA read data and the channel is enabled. Suspending the channel freezes the checksum, and accumulation resumes without loss when the suspend is released. Two status outputs report progress. A valid flag rises once the final beat of a transfer has been folded in. A discard flag rises when an abort or bus fault makes the partial result unusable.

The register holds the raw shift state. It applies no final inversion, so software complements the value it reads when it needs the conventional CRC-32 output.

Top module: `crc_beat_acc`

## Requirements
- R1: The update uses the reflected polynomial 0xEDB88320. Within a beat, the least significant byte is processed first, and within each byte the least significant bit is processed first. `crc_out` shows the raw register with no final inversion. With a seed of 0xFFFFFFFF, the nine bytes 0x31..0x39 leave 0x340BC6D9 in the register, which is the complement of 0xCBF43926.
- R2: `beat_size` 2'b00 folds `beat_data[7:0]`, 2'b01 folds `beat_data[15:0]`, and 2'b10 folds all 32 bits, each in a single clock. Code 2'b11 is reserved, and a beat carrying it leaves all state unchanged.
- R3: A write on `seed_we` loads `seed_data` into the checksum, and the new value is visible on `crc_out` one clock later. After reset, `crc_out` is 0xFFFFFFFF and both status flags are 0.
- R4: Beats are folded in only while `src_sel` equals 2'b01 (DMA read data) and `chan_en` is 1. Any other source code, or `chan_en` at 0, leaves the checksum and flags unchanged.
- R5: While `suspend` is 1, beats are not accepted and the checksum holds. Accumulation continues from the held value once `suspend` returns to 0.
- R6: A beat marked `last_beat` does not reset the checksum. The following beats keep accumulating from it, so linked blocks chain until a seed is written.
- R7: `result_valid` rises in the clock after an accepted beat marked `last_beat`. It is cleared by the next accepted beat not marked last, or by a fault. A seed write by itself leaves it unchanged.
- R8: `fault` sets `result_discard` in the next clock and blocks the beat presented in the same cycle. While the discard flag is set, no beat is accepted. Only a seed write clears the flag, and a fault in the same cycle as a seed write leaves the flag set.
- R9: When a seed write and an accepted beat arrive in the same cycle, the beat is folded starting from the new seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | CRC source select; 2'b01 selects DMA read data |
| chan_en | input | 1 | Channel enabled |
| suspend | input | 1 | Channel suspended; accumulation holds |
| beat_valid | input | 1 | A read beat is present |
| beat_data | input | 32 | Beat data, low bytes used for narrow beats |
| beat_size | input | 2 | 00 = 8 bit, 01 = 16 bit, 10 = 32 bit, 11 = reserved |
| last_beat | input | 1 | This beat ends the transfer |
| fault | input | 1 | Abort, descriptor error or bus fault |
| seed_we | input | 1 | Software write of the checksum register |
| seed_data | input | 32 | Seed value to load |
| crc_out | output | 32 | Current checksum register |
| result_valid | output | 1 | The final beat has been processed |
| result_discard | output | 1 | The partial result must be discarded |

## Verification
A corrupted checksum state appears on `crc_out` in the clock right after the faulty update and stays wrong for every later beat. For that reason the bench compares the full output state after every clock, not only at transfer ends. A gating error shows up as a checksum that moves during a cycle in which it should hold: a suspended or deselected cycle, a cycle with a reserved size code, or a cycle after a fault. A flag error shows up one clock after the last beat, the fault or the seed write that should have changed the flag. Mixed beat widths over the same bytes must reproduce the byte-wise result, which exposes byte-order or bit-order mistakes.

// File: rtl/crc_beat_acc.sv
module crc_beat_acc #(
  parameter logic [31:0] POLY      = 32'hEDB88320,
  parameter logic [31:0] RST_SEED  = 32'hFFFFFFFF,
  parameter logic [1:0]  SRC_DMA   = 2'b01,
  parameter int          DW        = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    src_sel,
  input  logic          chan_en,
  input  logic          suspend,
  input  logic          beat_valid,
  input  logic [DW-1:0] beat_data,
  input  logic [1:0]    beat_size,
  input  logic          last_beat,
  input  logic          fault,
  input  logic          seed_we,
  input  logic [31:0]   seed_data,
  output logic [31:0]   crc_out,
  output logic          result_valid,
  output logic          result_discard
);

  localparam int NBW = $clog2(DW + 1);

  logic [31:0]  crc_q;
  logic         valid_q;
  logic         disc_q;
  logic [NBW-1:0] nbits;
  logic         size_ok;
  logic         accept;
  logic [31:0]  base;
  logic [31:0]  folded;

  function automatic logic [31:0] fold_bits(input logic [31:0] c,
                                            input logic [DW-1:0] d,
                                            input logic [NBW-1:0] n);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < DW; i++) begin
      if (i < int'(n))
        r = (r >> 1) ^ ((r[0] ^ d[i]) ? POLY : 32'h0);
    end
    return r;
  endfunction

  always_comb begin
    size_ok = 1'b1;
    case (beat_size)
      2'b00:   nbits = NBW'(8);
      2'b01:   nbits = NBW'(16);
      2'b10:   nbits = NBW'(32);
      default: begin nbits = '0; size_ok = 1'b0; end
    endcase
  end

  assign accept = beat_valid && size_ok && (src_sel == SRC_DMA) && chan_en &&
                  !suspend && !fault && !(disc_q && !seed_we);
  assign base   = seed_we ? seed_data : crc_q;
  assign folded = fold_bits(base, beat_data, nbits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q   <= RST_SEED;
      valid_q <= 1'b0;
      disc_q  <= 1'b0;
    end else begin
      crc_q <= accept ? folded : base;
      if (fault)       valid_q <= 1'b0;
      else if (accept) valid_q <= last_beat;
      if (fault)        disc_q <= 1'b1;
      else if (seed_we) disc_q <= 1'b0;
    end
  end

  assign crc_out        = crc_q;
  assign result_valid   = valid_q;
  assign result_discard = disc_q;

  a_r3_seed_load: assert property (@(posedge clk) disable iff (!rst_n)
    seed_we && !beat_valid |=> crc_out == $past(seed_data));
  a_r4_source_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel != SRC_DMA || !chan_en) && !seed_we |=> $stable(crc_out));
  a_r5_suspend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    suspend && !seed_we |=> $stable(crc_out));
  a_r7_valid_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(result_valid) |-> $past(beat_valid && last_beat));
  a_r8_fault_discard: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> result_discard && !result_valid);
  a_r8_discard_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    result_discard && !seed_we |=> $stable(crc_out));

endmodule

// File: tb/crc_beat_acc_tb.sv
module crc_beat_acc_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] src_sel = 2'b01;
  logic chan_en = 1'b1, suspend = 1'b0, beat_valid = 1'b0, last_beat = 1'b0;
  logic fault = 1'b0, seed_we = 1'b0;
  logic [31:0] beat_data = '0, seed_data = '0;
  logic [1:0] beat_size = 2'b00;
  logic [31:0] crc_out;
  logic result_valid, result_discard;

  always #4 clk = ~clk;

  crc_beat_acc u_dut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .chan_en(chan_en),
    .suspend(suspend), .beat_valid(beat_valid), .beat_data(beat_data),
    .beat_size(beat_size), .last_beat(last_beat), .fault(fault),
    .seed_we(seed_we), .seed_data(seed_data), .crc_out(crc_out),
    .result_valid(result_valid), .result_discard(result_discard));

  typedef struct packed { logic [31:0] crc; logic v; logic d; } exp_t;
  exp_t  exq[$];
  string tagq[$];
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] m_crc = 32'hFFFFFFFF;
  logic m_v = 1'b0, m_d = 1'b0;

  function automatic logic [31:0] ref_fold(input logic [31:0] c, input logic [31:0] d, input int nbytes);
    logic [31:0] r = c;
    for (int b = 0; b < nbytes; b++) begin
      logic [7:0] by = d[8*b +: 8];
      for (int k = 0; k < 8; k++) begin
        logic fb = r[0] ^ by[k];
        r = r >> 1;
        if (fb) r = r ^ 32'hEDB88320;
      end
    end
    return r;
  endfunction

  task automatic cyc(input string tag);
    int nb;
    bit acc;
    logic [31:0] b;
    nb = (beat_size == 2'b00) ? 1 : (beat_size == 2'b01) ? 2 : (beat_size == 2'b10) ? 4 : 0;
    acc = beat_valid && nb != 0 && src_sel == 2'b01 && chan_en && !suspend && !fault &&
          !(m_d && !seed_we);
    b = seed_we ? seed_data : m_crc;
    m_crc = acc ? ref_fold(b, beat_data, nb) : b;
    if (fault) m_v = 1'b0; else if (acc) m_v = last_beat;
    if (fault) m_d = 1'b1; else if (seed_we) m_d = 1'b0;
    exq.push_back('{crc: m_crc, v: m_v, d: m_d});
    tagq.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle();
    beat_valid = 0; last_beat = 0; seed_we = 0; fault = 0; suspend = 0;
    src_sel = 2'b01; chan_en = 1; beat_size = 2'b00;
  endtask

  task automatic seed(input logic [31:0] s, input string tag);
    idle(); seed_we = 1; seed_data = s; cyc(tag); idle();
  endtask

  task automatic beat(input logic [31:0] d, input logic [1:0] sz, input bit lst, input string tag);
    idle(); beat_valid = 1; beat_data = d; beat_size = sz; last_beat = lst; cyc(tag); idle();
  endtask

  task automatic check9_bytes(input string tag);
    for (int i = 0; i < 9; i++) beat(32'h31 + i, 2'b00, i == 8, tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (exq.size() > 0) begin
      exp_t e;
      string t;
      e = exq.pop_front();
      t = tagq.pop_front();
      n_vec++;
      if (crc_out !== e.crc || result_valid !== e.v || result_discard !== e.d) begin
        n_bad++;
        $display("FAIL %s: got crc=%h v=%b d=%b expected crc=%h v=%b d=%b",
                 t, crc_out, result_valid, result_discard, e.crc, e.v, e.d);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    n_vec++;
    if (crc_out !== 32'hFFFFFFFF || result_valid !== 0 || result_discard !== 0) begin
      n_bad++;
      $display("FAIL R3 reset: got crc=%h v=%b d=%b expected crc=ffffffff v=0 d=0",
               crc_out, result_valid, result_discard);
    end
    rst_n = 1;
    @(negedge clk);

    // R1 standard check string byte by byte
    seed(32'hFFFFFFFF, "R3 seed load");
    check9_bytes("R1 byte stream");
    idle(); cyc("R7 valid after last");
    n_vec++;
    if (crc_out !== 32'h340BC6D9) begin
      n_bad++;
      $display("FAIL R1 check value: got %h expected 340bc6d9", crc_out);
    end

    // R2 mixed widths over the same bytes
    seed(32'hFFFFFFFF, "R3 seed reload");
    n_vec++;
    if (result_valid !== 1'b1) begin
      n_bad++;
      $display("FAIL R7 seed alone keeps valid: got %b expected 1", result_valid);
    end
    beat(32'h34333231, 2'b10, 0, "R2 32-bit beat");
    beat(32'hAAAA3635, 2'b01, 0, "R2 16-bit beat upper ignored");
    beat(32'h55553837, 2'b01, 0, "R2 16-bit beat");
    beat(32'hDEAD4439, 2'b00, 1, "R2 8-bit last beat");
    idle(); cyc("R2 mixed result");
    n_vec++;
    if (crc_out !== 32'h340BC6D9) begin
      n_bad++;
      $display("FAIL R2 mixed check value: got %h expected 340bc6d9", crc_out);
    end

    // R2 reserved size, R4 source and enable gating, R5 suspend
    seed(32'h12345678, "R3 seed arbitrary");
    beat(32'h11111111, 2'b11, 0, "R2 reserved size ignored");
    idle(); src_sel = 2'b00; beat_valid = 1; beat_data = 32'hCAFEF00D; beat_size = 2'b10; cyc("R4 source 00 gated");
    idle(); src_sel = 2'b10; beat_valid = 1; beat_data = 32'hCAFEF00D; beat_size = 2'b10; cyc("R4 source 10 gated");
    idle(); src_sel = 2'b11; beat_valid = 1; beat_data = 32'hCAFEF00D; beat_size = 2'b10; cyc("R4 source 11 gated");
    idle(); chan_en = 0; beat_valid = 1; beat_data = 32'hCAFEF00D; beat_size = 2'b10; cyc("R4 channel disabled");
    for (int i = 0; i < 3; i++) begin
      idle(); suspend = 1; beat_valid = 1; beat_data = 32'h0BADBEEF; beat_size = 2'b10; cyc("R5 suspended hold");
    end
    beat(32'h0BADBEEF, 2'b10, 0, "R5 resume after suspend");

    // R6 linked blocks continue, R7 valid clears on next beat
    beat(32'h000000A5, 2'b00, 1, "R6 block end");
    beat(32'h0000C3C3, 2'b01, 0, "R6 R7 next block carries, valid clears");
    beat(32'h76543210, 2'b10, 1, "R6 second block end");
    idle(); cyc("R7 hold");

    // R9 seed and beat same cycle
    idle(); seed_we = 1; seed_data = 32'hFFFFFFFF; beat_valid = 1; beat_data = 32'h34333231; beat_size = 2'b10; cyc("R9 seed with beat");
    idle();
    beat(32'h00003635, 2'b01, 0, "R9 continue");

    // R8 fault behaviour
    idle(); fault = 1; beat_valid = 1; beat_data = 32'h00000037; beat_size = 2'b00; cyc("R8 fault blocks beat");
    beat(32'h00000038, 2'b00, 1, "R8 discard blocks beats");
    beat(32'h00000039, 2'b10, 0, "R8 discard still blocks");
    idle(); seed_we = 1; seed_data = 32'h0; fault = 1; cyc("R8 fault wins over seed");
    seed(32'hA5A5A5A5, "R8 seed clears discard");
    beat(32'h00000037, 2'b00, 1, "R8 beats resume");
    idle(); fault = 1; cyc("R8 fault clears valid");
    idle(); seed_we = 1; seed_data = 32'hFFFFFFFF; beat_valid = 1; beat_data = 32'h31; beat_size = 2'b00; cyc("R8 R9 seed with beat while discarding");
    idle(); cyc("R8 settle");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule